// File: doc/BRIEF.md
# Programmable-Timing External Static Memory Controller

This block turns single internal read and write requests into cycles on a parallel bus for static devices: SRAM, NOR flash, or simple memory-mapped peripherals. Six chip selects are provided. Each select has its own pair of timing words, which set the following:

- strobe lengths,
- the delay from select to output enable,
- the spacing from address-valid to output enable,
- the write hold,
- the address hold,
- the recovery time after reads.

A small register port loads these words and a global enable word. A requester presents a request when `req_ready` is high. Read data comes back with a one-cycle `done` pulse.

The sequencer is one state machine with six states:

- `ST_IDLE`: all strobes are released.
- `ST_ADDR`: the one address-valid cycle. The chip select falls here.
- `ST_SETUP`: the read wait before output enable.
- `ST_RSTROBE`: output enable is low.
- `ST_WSTROBE`: write enable is low.
- `ST_WHOLD`: the select and the write data are kept after write enable rises.

The transitions are as follows:

- `IDLE->ADDR` on an accepted request to an enabled select.
- `ADDR->WSTROBE` for a write.
- `ADDR->SETUP` for a read whose output enable offset is above one.
- `ADDR->RSTROBE` for any other read.
- `SETUP->RSTROBE` when the setup count expires.
- `RSTROBE->IDLE` when the strobe count expires. This completes the read: the data is sampled and the recovery counter is loaded.
- `WSTROBE->WHOLD` when the strobe expires and the hold count is nonzero.
- `WSTROBE->IDLE` when the strobe expires and the hold count is zero.
- `WHOLD->IDLE` when the hold count expires.

Top module: `static_mem_ctrl`

## Requirements
- R1: After reset, every chip select, `ext_oe_n` and `ext_we_n` are high, `ext_addr_vld`, `ext_dq_oe` and `done` are low, `rd_data` is zero and `req_ready` is high. Reset clears the enable word and all timing words.
- R2: Each select has an enable field in the enable word, and the select is enabled when its field is nonzero. Select 0 owns bits [1:0], select 1 bits [3:2], select 2 bit 4, select 3 bit 5, select 4 bits [7:6] and select 5 bits [9:8]. A request to a disabled select, or with `req_sel` of 6 or 7, starts no bus cycle and gives no `done`.
- R3: Every access begins with exactly one cycle in which `ext_addr_vld` is high. The chip select falls in that same cycle and `ext_addr` carries the request address. In the following cycle `ext_addr` still carries the address if the select's address-hold bit is set, and is zero otherwise.
- R4: On a read, `ext_oe_n` falls max(1, read hold, address-valid-to-OE) cycles after the cycle in which the chip select falls.
- R5: On a read, `ext_oe_n` stays low for read-wait+1 cycles. The bus is sampled in the last of these cycles. In the next cycle the select is released, `done` pulses for one cycle and `rd_data` holds the sample.
- R6: On a write, `ext_we_n` is low for write-wait+1 cycles, starting in the cycle after address-valid. `ext_dq_oe` is high, with `ext_dq_out` equal to the write data, only during the write strobe and write hold cycles.
- R7: After the write strobe, the chip select stays low with `ext_we_n` high for write-hold cycles. `done` pulses in the first cycle after that.
- R8: Suppose a read completes and the next access either uses a different select or is a write to the same select. Then at least recovery+1 idle cycles, taken from the read's select, separate the two accesses. In every other case one idle cycle separates back-to-back accesses.
- R9: `req_ready` is high only in `ST_IDLE`, and only when the presented request is not held back by pending recovery.
- R10: The register port decodes `cfg_addr` as follows.
  - Address 0 is the enable word, bits [9:0].
  - Addresses 1 to 6 are timing word A for selects 0 to 5. In word A, bits [31:28] are recovery, [27:24] write hold, [7:4] write wait and [3:0] read wait. Bits [23:8] are accepted and have no effect.
  - Addresses 9 to 14 are timing word B for selects 0 to 5. In word B, bits [27:24] are read hold, [17:16] address-valid-to-OE and bit 5 is address hold.
- R11: At most one chip select is low at any time, and `ext_oe_n` and `ext_we_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 32 | Register write data |
| req | input | 1 | Access request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_sel | input | 3 | Chip select index |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request is accepted on this edge if `req` is high |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Last read data |
| ext_cs_n | output | 6 | Active-low chip selects |
| ext_oe_n | output | 1 | Active-low output enable |
| ext_we_n | output | 1 | Active-low write enable |
| ext_addr_vld | output | 1 | Address-valid strobe |
| ext_addr | output | ADDR_W | External address |
| ext_dq_out | output | DATA_W | Data driven to the bus |
| ext_dq_oe | output | 1 | Data bus driver enable |
| ext_dq_in | input | DATA_W | Data from the bus |

## Verification
Two things can fall in the same idle cycle: the completion of a read, which carries the `done` pulse and loads the recovery counter, and the arrival of the next request. The bench keeps its next request asserted from the very cycle in which `done` is seen. It counts both the cycles in which `req_ready` stays low and the run of cycles with every select high before the next chip select falls. These counts are compared against recovery+1 for a write, or a different select, after a read, and against one cycle for a same-select read or for any access after a write.

// File: rtl/smc_pkg.sv
package smc_pkg;

    localparam int NUM_CS = 6;
    localparam int SEL_W  = 3;
    localparam int CNT_W  = 4;
    localparam int EN_W   = 10;

    typedef struct packed {
        logic [CNT_W-1:0] recov;
        logic [CNT_W-1:0] whold;
        logic [CNT_W-1:0] wwait;
        logic [CNT_W-1:0] rwait;
        logic [CNT_W-1:0] rhold;
        logic [1:0]       adv_oe;
        logic             ahold;
    } cs_timing_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SETUP,
        ST_RSTROBE,
        ST_WSTROBE,
        ST_WHOLD
    } seq_state_t;

    function automatic logic sel_enabled(input logic [EN_W-1:0] en,
                                         input logic [SEL_W-1:0] sel);
        logic ok;
        case (sel)
            3'd0:    ok = |en[1:0];
            3'd1:    ok = |en[3:2];
            3'd2:    ok = en[4];
            3'd3:    ok = en[5];
            3'd4:    ok = |en[7:6];
            3'd5:    ok = |en[9:8];
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/smc_cfg_regs.sv
module smc_cfg_regs
    import smc_pkg::*;
#(
    parameter int NCS = NUM_CS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [3:0]           cfg_addr,
    input  logic [31:0]          cfg_wdata,
    input  logic [SEL_W-1:0]     sel,
    output logic [EN_W-1:0]      en_word,
    output cs_timing_t           tim
);

    cs_timing_t cs_tim [NCS];

    // delta fields and reserved bits are accepted without effect
    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{cfg_wdata[23:8], cfg_wdata[31:28] & 4'h0};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_word <= '0;
        end else if (cfg_we && cfg_addr == 4'd0) begin
            en_word <= cfg_wdata[EN_W-1:0];
        end
    end

    for (genvar g = 0; g < NCS; g++) begin : g_sel
        localparam logic [3:0] A_OFS = 4'(1 + g);
        localparam logic [3:0] B_OFS = 4'(9 + g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cs_tim[g] <= '0;
            end else if (cfg_we && cfg_addr == A_OFS) begin
                cs_tim[g].recov <= cfg_wdata[31:28];
                cs_tim[g].whold <= cfg_wdata[27:24];
                cs_tim[g].wwait <= cfg_wdata[7:4];
                cs_tim[g].rwait <= cfg_wdata[3:0];
            end else if (cfg_we && cfg_addr == B_OFS) begin
                cs_tim[g].rhold  <= cfg_wdata[27:24];
                cs_tim[g].adv_oe <= cfg_wdata[17:16];
                cs_tim[g].ahold  <= cfg_wdata[5];
            end
        end
    end

    always_comb begin
        tim = '0;
        for (int i = 0; i < NCS; i++) begin
            if (sel == i[SEL_W-1:0]) tim = cs_tim[i];
        end
    end

endmodule

// File: rtl/smc_seq.sv
module smc_seq
    import smc_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int NCS    = NUM_CS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [EN_W-1:0]   en_word,
    input  cs_timing_t        tim,
    output logic [SEL_W-1:0]  sel_q,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [NCS-1:0]    ext_cs_n,
    output logic              ext_oe_n,
    output logic              ext_we_n,
    output logic              ext_addr_vld,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_dq_out,
    output logic              ext_dq_oe,
    input  logic [DATA_W-1:0] ext_dq_in
);

    seq_state_t        state, nxt_state;
    logic [CNT_W-1:0]  cnt, nxt_cnt;
    logic [CNT_W-1:0]  rec_cnt;
    logic [CNT_W-1:0]  oe_start;
    logic              wr_q, ah_q, last_rd, finish, accept, rec_block;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    assign rec_block = last_rd && (rec_cnt != '0) && (req_wr || req_sel != sel_q);
    assign req_ready = (state == ST_IDLE) && !rec_block;
    assign accept    = req && req_ready && sel_enabled(en_word, req_sel);

    // output enable offset from the select-assert cycle
    always_comb begin
        oe_start = CNT_W'(1);
        if (tim.rhold > oe_start) oe_start = tim.rhold;
        if (CNT_W'(tim.adv_oe) > oe_start) oe_start = CNT_W'(tim.adv_oe);
    end

    // next-state
    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        finish    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (accept) nxt_state = ST_ADDR;
            end
            ST_ADDR: begin
                if (wr_q) begin
                    nxt_state = ST_WSTROBE;
                    nxt_cnt   = tim.wwait;
                end else if (oe_start > CNT_W'(1)) begin
                    nxt_state = ST_SETUP;
                    nxt_cnt   = oe_start - CNT_W'(2);
                end else begin
                    nxt_state = ST_RSTROBE;
                    nxt_cnt   = tim.rwait;
                end
            end
            ST_SETUP: begin
                if (cnt == '0) begin
                    nxt_state = ST_RSTROBE;
                    nxt_cnt   = tim.rwait;
                end else begin
                    nxt_cnt = cnt - 1'b1;
                end
            end
            ST_RSTROBE: begin
                if (cnt == '0) begin
                    nxt_state = ST_IDLE;
                    finish    = 1'b1;
                end else begin
                    nxt_cnt = cnt - 1'b1;
                end
            end
            ST_WSTROBE: begin
                if (cnt == '0) begin
                    if (tim.whold != '0) begin
                        nxt_state = ST_WHOLD;
                        nxt_cnt   = tim.whold - 1'b1;
                    end else begin
                        nxt_state = ST_IDLE;
                        finish    = 1'b1;
                    end
                end else begin
                    nxt_cnt = cnt - 1'b1;
                end
            end
            ST_WHOLD: begin
                if (cnt == '0) begin
                    nxt_state = ST_IDLE;
                    finish    = 1'b1;
                end else begin
                    nxt_cnt = cnt - 1'b1;
                end
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
        end
    end

    // request capture, completion and recovery tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= '0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            ah_q    <= 1'b0;
            done    <= 1'b0;
            rd_data <= '0;
            last_rd <= 1'b0;
            rec_cnt <= '0;
        end else begin
            if (accept) begin
                sel_q   <= req_sel;
                wr_q    <= req_wr;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            ah_q <= (state == ST_ADDR) && tim.ahold;
            done <= finish;
            if (finish && !wr_q) rd_data <= ext_dq_in;
            if (finish) begin
                last_rd <= !wr_q;
                rec_cnt <= wr_q ? '0 : tim.recov;
            end else if (rec_cnt != '0) begin
                rec_cnt <= rec_cnt - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        ext_cs_n = '1;
        for (int i = 0; i < NCS; i++) begin
            if (state != ST_IDLE && sel_q == i[SEL_W-1:0]) ext_cs_n[i] = 1'b0;
        end
        ext_addr_vld = (state == ST_ADDR);
        ext_addr     = (ext_addr_vld || ah_q) ? addr_q : '0;
        ext_oe_n     = (state != ST_RSTROBE);
        ext_we_n     = (state != ST_WSTROBE);
        ext_dq_oe    = (state == ST_WSTROBE) || (state == ST_WHOLD);
        ext_dq_out   = ext_dq_oe ? wdata_q : '0;
    end

endmodule

// File: rtl/static_mem_ctrl.sv
module static_mem_ctrl
    import smc_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              req,
    input  logic              req_wr,
    input  logic [2:0]        req_sel,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [5:0]        ext_cs_n,
    output logic              ext_oe_n,
    output logic              ext_we_n,
    output logic              ext_addr_vld,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_dq_out,
    output logic              ext_dq_oe,
    input  logic [DATA_W-1:0] ext_dq_in
);

    logic [EN_W-1:0]  en_word;
    logic [SEL_W-1:0] sel_q;
    cs_timing_t       tim;

    smc_cfg_regs #(.NCS(NUM_CS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .sel       (sel_q),
        .en_word   (en_word),
        .tim       (tim)
    );

    smc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCS(NUM_CS)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (req),
        .req_wr       (req_wr),
        .req_sel      (req_sel),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .en_word      (en_word),
        .tim          (tim),
        .sel_q        (sel_q),
        .req_ready    (req_ready),
        .done         (done),
        .rd_data      (rd_data),
        .ext_cs_n     (ext_cs_n),
        .ext_oe_n     (ext_oe_n),
        .ext_we_n     (ext_we_n),
        .ext_addr_vld (ext_addr_vld),
        .ext_addr     (ext_addr),
        .ext_dq_out   (ext_dq_out),
        .ext_dq_oe    (ext_dq_oe),
        .ext_dq_in    (ext_dq_in)
    );

endmodule

// File: rtl/static_mem_ctrl_chk.sv
module static_mem_ctrl_chk
    import smc_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [5:0]      ext_cs_n,
    input logic            ext_oe_n,
    input logic            ext_we_n,
    input logic            ext_addr_vld,
    input logic            ext_dq_oe,
    input logic            done,
    input logic            req_ready,
    input logic [EN_W-1:0] en_word
);

    logic cs_act;
    logic en_ok;

    assign cs_act = ~&ext_cs_n;

    always_comb begin
        en_ok = 1'b0;
        for (int i = 0; i < 6; i++) begin
            if (!ext_cs_n[i]) en_ok = sel_enabled(en_word, i[SEL_W-1:0]);
        end
    end

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ext_cs_n)); // R11
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_oe_n && !ext_we_n)); // R11
    AST_ADV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_addr_vld |=> !ext_addr_vld); // R3
    AST_CS_OPENS_WITH_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_act) |-> ext_addr_vld); // R3
    AST_OE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_oe_n |-> (cs_act && !ext_addr_vld)); // R4
    AST_DQ_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ext_dq_oe |-> (cs_act && ext_oe_n)); // R6
    AST_DONE_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!cs_act && $past(cs_act))); // R5
    AST_ENABLED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ext_addr_vld |-> en_ok); // R2
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !cs_act); // R9

endmodule

bind static_mem_ctrl static_mem_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_cs_n     (ext_cs_n),
    .ext_oe_n     (ext_oe_n),
    .ext_we_n     (ext_we_n),
    .ext_addr_vld (ext_addr_vld),
    .ext_dq_oe    (ext_dq_oe),
    .done         (done),
    .req_ready    (req_ready),
    .en_word      (en_word)
);

// File: tb/static_mem_ctrl_tb.sv
module static_mem_ctrl_tb;

    localparam int AW = 20;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [3:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic          req = 1'b0;
    logic          req_wr = 1'b0;
    logic [2:0]    req_sel = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, done;
    logic [DW-1:0] rd_data;
    logic [5:0]    ext_cs_n;
    logic          ext_oe_n, ext_we_n, ext_addr_vld, ext_dq_oe;
    logic [AW-1:0] ext_addr;
    logic [DW-1:0] ext_dq_out, ext_dq_in;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    static_mem_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req(req), .req_wr(req_wr), .req_sel(req_sel),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .done(done), .rd_data(rd_data), .ext_cs_n(ext_cs_n), .ext_oe_n(ext_oe_n),
        .ext_we_n(ext_we_n), .ext_addr_vld(ext_addr_vld), .ext_addr(ext_addr),
        .ext_dq_out(ext_dq_out), .ext_dq_oe(ext_dq_oe), .ext_dq_in(ext_dq_in)
    );

    // bus model: value changes with each output-enable cycle
    logic [DW-1:0] oe_run = '0;
    always @(posedge clk) oe_run <= ext_oe_n ? '0 : oe_run + 1'b1;
    assign ext_dq_in = 16'hA500 + oe_run;

    // idle-gap monitor
    int idle_run = 0;
    int last_gap = 0;
    always @(negedge clk) begin
        if (&ext_cs_n) idle_run <= idle_run + 1;
        else if (idle_run > 0) begin
            last_gap <= idle_run;
            idle_run <= 0;
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // observations of one access
    int o_waits, o_oe_first, o_oe_cnt, o_we_first, o_we_cnt, o_dqoe_cnt, o_cs_cnt, o_done_c;
    logic [AW-1:0] o_addr0, o_addr1;
    logic [DW-1:0] o_rdata;
    bit o_dq_bad, o_cs_bad;

    // called at a negedge; returns at the negedge of the done cycle
    task automatic run_access(input logic wr, input logic [2:0] sel,
                              input logic [AW-1:0] a, input logic [DW-1:0] wd);
        o_waits = 0; o_oe_first = -1; o_oe_cnt = 0; o_we_first = -1; o_we_cnt = 0;
        o_dqoe_cnt = 0; o_cs_cnt = 0; o_done_c = -1; o_dq_bad = 0; o_cs_bad = 0;
        o_addr0 = '0; o_addr1 = '0; o_rdata = '0;
        req = 1'b1; req_wr = wr; req_sel = sel; req_addr = a; req_wdata = wd;
        #1;
        while (!req_ready && o_waits < 40) begin
            @(negedge clk); #1;
            o_waits++;
        end
        @(negedge clk);
        req = 1'b0;
        for (int c = 0; c < 64; c++) begin
            if (!(&ext_cs_n)) begin
                o_cs_cnt++;
                if (ext_cs_n != ~(6'b1 << sel)) o_cs_bad = 1;
            end
            if (!ext_oe_n) begin
                if (o_oe_first < 0) o_oe_first = c;
                o_oe_cnt++;
            end
            if (!ext_we_n) begin
                if (o_we_first < 0) o_we_first = c;
                o_we_cnt++;
            end
            if (ext_dq_oe) begin
                o_dqoe_cnt++;
                if (ext_dq_out != wd) o_dq_bad = 1;
            end
            if (c == 0) o_addr0 = ext_addr;
            if (c == 1) o_addr1 = ext_addr;
            if (done) begin
                o_done_c = c;
                o_rdata = rd_data;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk(ext_cs_n == 6'h3F, "R1 cs idle", ext_cs_n, 6'h3F);
        chk(ext_oe_n && ext_we_n, "R1 strobes high", {ext_oe_n, ext_we_n}, 2'b11);
        chk(!ext_addr_vld && !ext_dq_oe && !done, "R1 adv/dq_oe/done low",
            {ext_addr_vld, ext_dq_oe, done}, 0);
        chk(rd_data == '0, "R1 rd_data", rd_data, 0);
        chk(req_ready, "R1 ready", req_ready, 1);
    endtask

    // reset cleared every enable, so nothing may start
    task automatic t_disabled_after_reset();
        bit seen = 0;
        req = 1'b1; req_wr = 1'b0; req_sel = 3'd0; req_addr = 20'h1;
        repeat (4) begin
            @(negedge clk);
            if (!(&ext_cs_n) || done) seen = 1;
        end
        req = 1'b0;
        chk(!seen, "R1 R2 enables cleared by reset", seen, 0);
    endtask

    task automatic t_config();
        // select 0 field=01, select 1 field=10, select 3 set, select 5 field=11
        cfg_write(4'd0, 32'h0000_0329);
        cfg_write(4'd1, {4'h3, 4'h2, 8'hFF, 8'hEE, 4'h1, 4'h2});
        cfg_write(4'd9, 32'h8502_0020 | 32'h0000_0100);
        cfg_write(4'd2, {4'h0, 4'h0, 8'h55, 8'h55, 4'h0, 4'h0});
        cfg_write(4'd10, 32'h0000_0000);
        cfg_write(4'd4, {4'h1, 4'h0, 8'h00, 8'h00, 4'h3, 4'h3});
        cfg_write(4'd12, 32'h0103_0000);
        cfg_write(4'd6, {4'h0, 4'hF, 8'h00, 8'h00, 4'hF, 4'h0});
        cfg_write(4'd14, 32'h0F00_0000);
    endtask

    task automatic t_read_sel0_first();
        run_access(1'b0, 3'd0, 20'h1_2345, '0);
        chk(o_oe_first == 5, "R4 R10 sel0 oe offset", o_oe_first, 5);
        chk(o_oe_cnt == 3, "R5 sel0 oe length", o_oe_cnt, 3);
        chk(o_cs_cnt == 8 && !o_cs_bad, "R11 sel0 read cs span", o_cs_cnt, 8);
        chk(o_done_c == 8, "R5 sel0 done cycle", o_done_c, 8);
        chk(o_rdata == 16'hA502, "R5 sampled on last oe cycle", o_rdata, 16'hA502);
        chk(o_addr0 == 20'h1_2345, "R3 address in adv cycle", o_addr0, 20'h1_2345);
        chk(o_addr1 == 20'h1_2345, "R3 address hold on", o_addr1, 20'h1_2345);
        chk(o_we_cnt == 0 && o_dqoe_cnt == 0, "R6 no write strobe on read",
            o_we_cnt + o_dqoe_cnt, 0);
    endtask

    task automatic t_write_after_read_same();
        run_access(1'b1, 3'd0, 20'h0_0042, 16'hBEEF);
        chk(o_waits == 3, "R9 ready held during recovery", o_waits, 3);
        chk(last_gap == 4, "R8 recovery read->write same select", last_gap, 4);
        chk(o_we_first == 1 && o_we_cnt == 2, "R6 write strobe", o_we_cnt, 2);
        chk(o_dqoe_cnt == 4 && !o_dq_bad, "R6 R7 data driven strobe+hold", o_dqoe_cnt, 4);
        chk(o_cs_cnt == 5 && o_done_c == 5, "R7 write hold then done", o_cs_cnt, 5);
        chk(o_oe_cnt == 0, "R11 no oe on write", o_oe_cnt, 0);
    endtask

    task automatic t_read_read_same();
        run_access(1'b0, 3'd0, 20'h0_0010, '0);
        chk(last_gap == 1, "R8 write->read single idle", last_gap, 1);
        run_access(1'b0, 3'd0, 20'h0_0011, '0);
        chk(o_waits == 0, "R9 no hold-off read->read same", o_waits, 0);
        chk(last_gap == 1, "R8 read->read same select", last_gap, 1);
    endtask

    task automatic t_sel1_minimal();
        run_access(1'b0, 3'd1, 20'h0_0777, '0);
        chk(last_gap == 4, "R8 recovery on select change", last_gap, 4);
        chk(o_oe_first == 1 && o_oe_cnt == 1, "R4 minimum oe offset", o_oe_first, 1);
        chk(o_rdata == 16'hA500, "R5 single-cycle read data", o_rdata, 16'hA500);
        chk(o_addr1 == '0, "R3 address hold off", o_addr1, 0);
        run_access(1'b1, 3'd1, 20'h0_0778, 16'h1234);
        chk(last_gap == 1, "R8 zero recovery field", last_gap, 1);
        chk(o_we_cnt == 1 && o_dqoe_cnt == 1 && o_done_c == 2,
            "R6 R7 write without hold", o_dqoe_cnt, 1);
    endtask

    task automatic t_sel3_sel5();
        run_access(1'b0, 3'd3, 20'h0_0300, '0);
        chk(o_oe_first == 3 && o_oe_cnt == 4, "R4 adv-to-oe spacing wins", o_oe_first, 3);
        chk(o_rdata == 16'hA503, "R5 sel3 read data", o_rdata, 16'hA503);
        run_access(1'b0, 3'd5, 20'h0_0500, '0);
        chk(last_gap == 2 && o_waits == 1, "R8 recovery 1 from sel3", last_gap, 2);
        chk(o_oe_first == 15, "R4 maximum read hold", o_oe_first, 15);
        run_access(1'b1, 3'd5, 20'h0_0501, 16'hC0DE);
        chk(o_we_cnt == 16 && o_dqoe_cnt == 31 && o_cs_cnt == 32 && !o_dq_bad,
            "R6 R7 maximum write timing", o_cs_cnt, 32);
    endtask

    task automatic t_reject(input logic [2:0] sel);
        bit seen = 0;
        req = 1'b1; req_wr = 1'b1; req_sel = sel; req_addr = 20'h0_0099;
        repeat (6) begin
            @(negedge clk);
            if (!(&ext_cs_n) || done || ext_addr_vld) seen = 1;
        end
        req = 1'b0;
        chk(!seen, $sformatf("R2 select %0d ignored", sel), seen, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        @(negedge clk);
        t_disabled_after_reset();
        @(negedge clk);
        t_config();
        t_read_sel0_first();
        t_write_after_read_same();
        t_read_read_same();
        t_sel1_minimal();
        t_sel3_sel5();
        @(negedge clk);
        t_reject(3'd2);
        t_reject(3'd4);
        t_reject(3'd6);
        t_reject(3'd7);
        @(negedge clk);
        run_access(1'b0, 3'd3, 20'h0_0301, '0);
        chk(o_done_c == 7, "R2 enabled select works after rejects", o_done_c, 7);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule